// File: doc/BRIEF.md
# Raster Timing Generator with Vertical Genlock

This block turns a video clock into raster timing. A horizontal counter steps once per clock and wraps at a programmed line total. A vertical counter steps once per line and wraps at a programmed frame total. Registered, active-low outputs for horizontal sync, horizontal blank and vertical blank are decoded from the two counts. The vertical sync signal has its own direction. In master mode the block drives it from the vertical count and raises its output enable. In slave mode the enable is low and the block watches an external sync pulse instead. After a falling edge of that pulse, the vertical count is forced to a programmed line number at the next line end. This lets the raster follow an outside source and absorb any delay the outside source adds before its sync arrives.

Software programs the totals, the sync and blank windows, the genlock target line and the direction bit through a single-cycle write port. Every write goes into a shadow copy. The shadow copy moves into the working set only at the start of a frame, so the frame being scanned is never changed part way through. Everything runs on the video clock. The external sync is the only asynchronous input.

Top module: `vtg_top`

## Requirements
- R1: During reset and in the first cycle after it, hsync_n, hblank_n, vblank_n and vsync_o are 1 and vsync_oe is 0. The reset working set is in slave mode with line total 19, hsync end 3, hblank 16 to 2, frame total 11, vsync end 2, vblank 10 to 1 and genlock line 5.
- R2: The horizontal count runs from 0 to the line total and then returns to 0, so one line lasts line total + 1 clocks.
- R3: hsync_n is registered. In the cycle after a clock edge it is 0 exactly when the count before that edge was in the range [0, hsync end).
- R4: hblank_n is registered in the same way and is 0 for counts in the range [start, end). When start > end the window wraps: it covers counts ≥ start or counts < end.
- R5: The vertical count advances by one at each line end and returns to 0 after the frame total. vblank_n uses the same wrap-aware window rule on the vertical count, also registered.
- R6: In master mode (control bit 0 = 1), vsync_oe is 1 and vsync_o is 0 while the vertical count is in the range [0, vsync end). The register stage is the same as in R3.
- R7: In slave mode (control bit 0 = 0), vsync_oe is 0 and vsync_o stays at 1.
- R8: In slave mode, vsync_i passes through two synchronizing flops. Each high-to-low transition is detected once, however long the input stays low. The line end that follows the detection loads the genlock line into the vertical count and sets the horizontal count to 0.
- R9: In master mode, vsync_i has no effect on any output.
- R10: A write goes only to a shadow copy. The shadow copy is moved into the working set on the clock edge at a line end where the next vertical count is 0. That edge is the frame start, whether it comes from a natural wrap or from genlock to line 0.
- R11: Write addresses are as follows. All fields take wr_data directly except the control field. Any other address is ignored.

  | Address | Field |
  |---|---|
  | 0 | line total |
  | 1 | hsync end |
  | 2 | hblank start |
  | 3 | hblank end |
  | 4 | frame total |
  | 5 | vsync end |
  | 6 | vblank start |
  | 7 | vblank end |
  | 8 | genlock line |
  | 9 | control (bit 0 only) |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 12 | Register write data |
| vsync_i | input | 1 | External active-low vertical sync (asynchronous) |
| vsync_o | output | 1 | Active-low vertical sync to drive out |
| vsync_oe | output | 1 | Output enable for vsync_o, high in master mode |
| hsync_n | output | 1 | Active-low horizontal sync |
| hblank_n | output | 1 | Active-low horizontal blank |
| vblank_n | output | 1 | Active-low vertical blank |

## Verification
The counter properties assume the working set is consistent. The horizontal count must never start above the line total. The vertical count must never start above the frame total. The genlock line must not exceed the frame total. The stimulus only programs totals that are at least as large as every window edge and genlock line. The one-shot edge property assumes each external pulse stays low and then high for at least three clocks, and the bench holds every pulse and every gap for many clocks.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    localparam int unsigned CNT_W  = 12;
    localparam int unsigned ADDR_W = 4;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_LINE_TOT  = 4'd0,
        RA_HS_END    = 4'd1,
        RA_HB_START  = 4'd2,
        RA_HB_END    = 4'd3,
        RA_FRAME_TOT = 4'd4,
        RA_VS_END    = 4'd5,
        RA_VB_START  = 4'd6,
        RA_VB_END    = 4'd7,
        RA_LOCK_LINE = 4'd8,
        RA_CONTROL   = 4'd9
    } vtg_addr_e;

    typedef struct packed {
        cnt_t line_tot;
        cnt_t hs_end;
        cnt_t hb_start;
        cnt_t hb_end;
        cnt_t frame_tot;
        cnt_t vs_end;
        cnt_t vb_start;
        cnt_t vb_end;
        cnt_t lock_line;
        logic master;
    } vtg_cfg_t;

    localparam vtg_cfg_t CFG_AT_RESET = '{
        line_tot:  cnt_t'(19),
        hs_end:    cnt_t'(3),
        hb_start:  cnt_t'(16),
        hb_end:    cnt_t'(2),
        frame_tot: cnt_t'(11),
        vs_end:    cnt_t'(2),
        vb_start:  cnt_t'(10),
        vb_end:    cnt_t'(1),
        lock_line: cnt_t'(5),
        master:    1'b0
    };

    // Wrap-aware window test: [lo, hi) when lo <= hi, otherwise c >= lo or c < hi.
    function automatic logic in_win(cnt_t c, cnt_t lo, cnt_t hi);
        if (lo <= hi) begin
            return (c >= lo) && (c < hi);
        end
        return (c >= lo) || (c < hi);
    endfunction

endpackage

// File: rtl/vtg_cfg_regs.sv
module vtg_cfg_regs
    import vtg_pkg::*;
#(
    parameter vtg_cfg_t RESET_CFG = CFG_AT_RESET
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  cnt_t              wr_data,
    input  logic              frame_load,
    output vtg_cfg_t          cfg_act
);

    vtg_cfg_t shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= RESET_CFG;
        end else if (wr_en) begin
            case (vtg_addr_e'(wr_addr))
                RA_LINE_TOT:  shadow.line_tot  <= wr_data;
                RA_HS_END:    shadow.hs_end    <= wr_data;
                RA_HB_START:  shadow.hb_start  <= wr_data;
                RA_HB_END:    shadow.hb_end    <= wr_data;
                RA_FRAME_TOT: shadow.frame_tot <= wr_data;
                RA_VS_END:    shadow.vs_end    <= wr_data;
                RA_VB_START:  shadow.vb_start  <= wr_data;
                RA_VB_END:    shadow.vb_end    <= wr_data;
                RA_LOCK_LINE: shadow.lock_line <= wr_data;
                RA_CONTROL:   shadow.master    <= wr_data[0];
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_act <= RESET_CFG;
        end else if (frame_load) begin
            cfg_act <= shadow;
        end
    end

endmodule

// File: rtl/vtg_vsync_in.sv
module vtg_vsync_in #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic vsync_async,
    output logic fall_det
);

    logic [SYNC_STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '1;
        end else begin
            pipe <= {pipe[SYNC_STAGES-1:0], vsync_async};
        end
    end

    // Last synchronized level high, new synchronized level low.
    assign fall_det = pipe[SYNC_STAGES] & ~pipe[SYNC_STAGES-1];

endmodule

// File: rtl/vtg_timer.sv
module vtg_timer
    import vtg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cnt_t line_tot,
    input  cnt_t frame_tot,
    input  cnt_t lock_line,
    input  logic master,
    input  logic ext_fall,
    output cnt_t h_cnt,
    output cnt_t v_cnt,
    output logic lock_pend,
    output logic frame_load
);

    logic line_end;
    logic trig;
    cnt_t v_next;

    assign line_end = (h_cnt == line_tot);
    assign trig     = ext_fall & ~master;

    always_comb begin
        v_next = v_cnt;
        if (line_end) begin
            if (lock_pend) begin
                v_next = lock_line;
            end else if (v_cnt == frame_tot) begin
                v_next = '0;
            end else begin
                v_next = v_cnt + cnt_t'(1);
            end
        end
    end

    assign frame_load = line_end && (v_next == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            h_cnt     <= '0;
            v_cnt     <= '0;
            lock_pend <= 1'b0;
        end else begin
            v_cnt <= v_next;
            if (line_end) begin
                h_cnt     <= '0;
                lock_pend <= trig;
            end else begin
                h_cnt     <= h_cnt + cnt_t'(1);
                lock_pend <= lock_pend | trig;
            end
        end
    end

endmodule

// File: rtl/vtg_top.sv
module vtg_top
    import vtg_pkg::*;
#(
    parameter vtg_cfg_t RESET_CFG = CFG_AT_RESET
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              vsync_i,
    output logic              vsync_o,
    output logic              vsync_oe,
    output logic              hsync_n,
    output logic              hblank_n,
    output logic              vblank_n
);

    vtg_cfg_t cfg_act;
    cnt_t     h_cnt;
    cnt_t     v_cnt;
    logic     ext_fall;
    logic     lock_pend;
    logic     frame_load;

    vtg_cfg_regs #(.RESET_CFG(RESET_CFG)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .frame_load (frame_load),
        .cfg_act    (cfg_act)
    );

    vtg_vsync_in #(.SYNC_STAGES(2)) u_sync (
        .clk         (clk),
        .rst         (rst),
        .vsync_async (vsync_i),
        .fall_det    (ext_fall)
    );

    vtg_timer u_timer (
        .clk        (clk),
        .rst        (rst),
        .line_tot   (cfg_act.line_tot),
        .frame_tot  (cfg_act.frame_tot),
        .lock_line  (cfg_act.lock_line),
        .master     (cfg_act.master),
        .ext_fall   (ext_fall),
        .h_cnt      (h_cnt),
        .v_cnt      (v_cnt),
        .lock_pend  (lock_pend),
        .frame_load (frame_load)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hsync_n  <= 1'b1;
            hblank_n <= 1'b1;
            vblank_n <= 1'b1;
            vsync_o  <= 1'b1;
            vsync_oe <= 1'b0;
        end else begin
            hsync_n  <= ~in_win(h_cnt, '0, cfg_act.hs_end);
            hblank_n <= ~in_win(h_cnt, cfg_act.hb_start, cfg_act.hb_end);
            vblank_n <= ~in_win(v_cnt, cfg_act.vb_start, cfg_act.vb_end);
            vsync_o  <= ~(cfg_act.master & in_win(v_cnt, '0, cfg_act.vs_end));
            vsync_oe <= cfg_act.master;
        end
    end

endmodule

// File: rtl/vtg_chk.sv
module vtg_chk
    import vtg_pkg::*;
(
    input logic clk,
    input logic rst,
    input cnt_t h_cnt,
    input cnt_t v_cnt,
    input cnt_t line_tot,
    input cnt_t frame_tot,
    input cnt_t lock_line,
    input logic master,
    input logic ext_fall,
    input logic lock_pend,
    input logic vsync_o,
    input logic vsync_oe
);

    // R2
    h_step_chk: assert property (@(posedge clk) disable iff (rst)
        (h_cnt != line_tot) |=> (h_cnt == cnt_t'($past(h_cnt) + cnt_t'(1))));

    // R2
    h_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (h_cnt == line_tot) |=> (h_cnt == '0));

    // R5
    v_step_chk: assert property (@(posedge clk) disable iff (rst)
        ((h_cnt == line_tot) && !lock_pend && (v_cnt != frame_tot))
        |=> (v_cnt == cnt_t'($past(v_cnt) + cnt_t'(1))));

    // R8
    genlock_chk: assert property (@(posedge clk) disable iff (rst)
        ((h_cnt == line_tot) && lock_pend) |=> (v_cnt == $past(lock_line)));

    // R8
    one_shot_chk: assert property (@(posedge clk) disable iff (rst)
        ext_fall |=> !ext_fall);

    // R7
    slave_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !vsync_oe |-> vsync_o);

    // R9
    master_nolock_chk: assert property (@(posedge clk) disable iff (rst)
        (master && !lock_pend) |=> !lock_pend);

endmodule

bind vtg_top vtg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .h_cnt     (h_cnt),
    .v_cnt     (v_cnt),
    .line_tot  (cfg_act.line_tot),
    .frame_tot (cfg_act.frame_tot),
    .lock_line (cfg_act.lock_line),
    .master    (cfg_act.master),
    .ext_fall  (ext_fall),
    .lock_pend (lock_pend),
    .vsync_o   (vsync_o),
    .vsync_oe  (vsync_oe)
);

// File: tb/vtg_top_tb.sv
module vtg_top_tb;

    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic          vsync_i = 1'b1;
    logic          vsync_o, vsync_oe, hsync_n, hblank_n, vblank_n;

    int n_cmp = 0;
    int n_bad = 0;
    string phase = "R1 reset";

    vtg_top u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .vsync_i(vsync_i), .vsync_o(vsync_o),
        .vsync_oe(vsync_oe), .hsync_n(hsync_n), .hblank_n(hblank_n),
        .vblank_n(vblank_n)
    );

    always #4 clk = ~clk;

    typedef struct {
        int lt, hse, hbs, hbe, ft, vse, vbs, vbe, ll;
        bit ms;
    } mcfg_t;

    typedef struct {
        bit vo, oe, hs, hb, vb;
    } exp_t;

    exp_t  sb_q[$];
    mcfg_t sh, ac;
    int    mh, mv;
    bit    mpend, s1, s2, s3;

    function automatic bit win(int c, int lo, int hi);
        if (lo <= hi) return (c >= lo) && (c < hi);
        return (c >= lo) || (c < hi);
    endfunction

    function automatic mcfg_t rcfg();
        mcfg_t c;
        c.lt = 19; c.hse = 3; c.hbs = 16; c.hbe = 2; c.ft = 11;
        c.vse = 2; c.vbs = 10; c.vbe = 1; c.ll = 5; c.ms = 1'b0;
        return c;
    endfunction

    // Reference model: pushes the outputs expected after each edge.
    always @(posedge clk) begin
        if (rst) begin
            sh = rcfg(); ac = rcfg();
            mh = 0; mv = 0; mpend = 0; s1 = 1; s2 = 1; s3 = 1;
            sb_q.delete();
        end else begin
            exp_t e;
            bit fall, le, trig;
            int nh, nv;
            bit np;
            mcfg_t old_sh;
            e.hs = !win(mh, 0, ac.hse);
            e.hb = !win(mh, ac.hbs, ac.hbe);
            e.vb = !win(mv, ac.vbs, ac.vbe);
            e.vo = !(ac.ms && win(mv, 0, ac.vse));
            e.oe = ac.ms;
            sb_q.push_back(e);
            fall = s3 && !s2;
            trig = fall && !ac.ms;
            le = (mh == ac.lt);
            if (le) begin
                nh = 0;
                nv = mpend ? ac.ll : ((mv == ac.ft) ? 0 : mv + 1);
                np = trig;
            end else begin
                nh = mh + 1; nv = mv; np = mpend | trig;
            end
            old_sh = sh;
            if (wr_en) begin
                case (wr_addr)
                    4'd0: sh.lt  = int'(wr_data);
                    4'd1: sh.hse = int'(wr_data);
                    4'd2: sh.hbs = int'(wr_data);
                    4'd3: sh.hbe = int'(wr_data);
                    4'd4: sh.ft  = int'(wr_data);
                    4'd5: sh.vse = int'(wr_data);
                    4'd6: sh.vbs = int'(wr_data);
                    4'd7: sh.vbe = int'(wr_data);
                    4'd8: sh.ll  = int'(wr_data);
                    4'd9: sh.ms  = wr_data[0];
                    default: ;
                endcase
            end
            if (le && nv == 0) ac = old_sh;
            mh = nh; mv = nv; mpend = np;
            s3 = s2; s2 = s1; s1 = vsync_i;
        end
    end

    task automatic cmp1(string sig, string req, bit act, bit exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] %s: actual %0b expected %0b at %0t",
                     req, phase, sig, act, exp, $time);
        end
    endtask

    // Monitor: compares at the falling edge.
    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            cmp1("hsync_n",  "R3", hsync_n,  e.hs);
            cmp1("hblank_n", "R4", hblank_n, e.hb);
            cmp1("vblank_n", "R5", vblank_n, e.vb);
            cmp1("vsync_o",  e.oe ? "R6" : "R7", vsync_o,  e.vo);
            cmp1("vsync_oe", e.oe ? "R6" : "R7", vsync_oe, e.oe);
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wreg(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = CW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ext_pulse(int low_len);
        @(negedge clk);
        vsync_i = 1'b0;
        wait_clk(low_len);
        vsync_i = 1'b1;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #200000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: outputs during reset
        wait_clk(4);
        cmp1("hsync_n",  "R1", hsync_n,  1'b1);
        cmp1("hblank_n", "R1", hblank_n, 1'b1);
        cmp1("vblank_n", "R1", vblank_n, 1'b1);
        cmp1("vsync_o",  "R1", vsync_o,  1'b1);
        cmp1("vsync_oe", "R1", vsync_oe, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        // R1: first cycle after reset, slave mode
        cmp1("vsync_oe", "R1", vsync_oe, 1'b0);

        phase = "R2 R5 free run slave";
        wait_clk(520);

        phase = "R8 genlock pulse";
        wait_clk(37);
        ext_pulse(45);
        wait_clk(300);
        ext_pulse(4);
        wait_clk(260);

        phase = "R8 genlock near frame end";
        wait_clk(200);
        ext_pulse(10);
        wait_clk(300);

        phase = "R10 R11 deferred writes";
        wait_clk(13);
        wreg(0, 23);
        wreg(1, 5);
        wreg(2, 2);
        wreg(3, 20);
        wreg(4, 9);
        wreg(5, 3);
        wreg(6, 0);
        wreg(7, 2);
        wreg(8, 0);
        wreg(12, 7);
        wreg(9, 1);
        wait_clk(600);

        phase = "R6 R9 master ignores vsync_i";
        ext_pulse(30);
        wait_clk(100);
        ext_pulse(6);
        wait_clk(400);

        phase = "R10 back to slave, lock line 0";
        wreg(9, 0);
        wreg(6, 8);
        wreg(7, 1);
        wait_clk(500);
        ext_pulse(20);
        wait_clk(600);

        phase = "R7 R8 lock line 3 wrapped blank";
        wreg(8, 3);
        wreg(2, 21);
        wreg(3, 4);
        wait_clk(400);
        ext_pulse(8);
        wait_clk(500);

        finish_run();
    end

endmodule